// File: doc/BRIEF.md
# Single-to-Double Floating-Point Widener

This block takes a 32-bit IEEE-754 binary32 word and returns the binary64 word that holds the same value. Widening never loses precision, so the block needs no rounding logic and raises no exception flags. It sorts the input into one of five classes: zero, subnormal, normal, infinity or NaN. Each class has its own way of building the wider word.

Normal inputs keep their fraction, shifted up to the top of the wider field, and get their exponent rebiased. Subnormal inputs become normal binary64 numbers: a leading-zero count finds the highest set fraction bit, that bit becomes the hidden one, and the exponent is lowered to match. Infinities and NaNs get an all-ones exponent and a fixed placement rule for the fraction. The quiet bit moves to the top of the wide fraction, and the other payload bits stay right-aligned at the bottom.

A valid strobe travels with the data. A parameter chooses whether the result is registered, giving one cycle of latency, or passes straight through.

Top module: `fp_widen_s2d`

## Requirements
- R1: A normal input (biased exponent 1..254) gives output exponent = input exponent + 896 in bits 62:52. The 23 input fraction bits appear in output bits 51:29, and output bits 28:0 are zero.
- R2: An input whose bits 30:0 are all zero gives an output whose bits 62:0 are all zero.
- R3: A subnormal input (exponent 0, fraction nonzero) has its highest set fraction bit at index p (0..22). The output exponent is 874 + p. The fraction bits below p appear left-aligned in output bits 51:(52-p), and all lower bits are zero.
- R4: An infinity (exponent 255, fraction zero) gives exponent field 0x7FF and an all-zero fraction.
- R5: A NaN (exponent 255, fraction nonzero) gives exponent field 0x7FF. Input bit 22 goes to output bit 51, input bits 21:0 go to output bits 21:0, and output bits 50:22 are zero.
- R6: Output bit 63 equals input bit 31 for every input class.
- R7: With the output register enabled (default), out_valid equals in_valid one clock earlier, and out_word carries the result for the word presented in that cycle.
- R8: While in_valid is low, out_word keeps its previous value and out_valid is low one cycle later.
- R9: While rst_n is low, out_valid is low.
- R10: The boundary words convert exactly: the largest subnormal 0x007FFFFF gives 0x380FFFFFC0000000, the smallest normal 0x00800000 gives 0x3810000000000000, and the largest finite 0x7F7FFFFF gives 0x47EFFFFFE0000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | binary32 operand |
| out_valid | output | 1 | Result word is valid |
| out_word | output | 64 | binary64 result |

## Verification
The bench walks a single set bit through every subnormal fraction position. A wrong leading-zero count would be off by one in the exponent, or would leave the hidden bit set in the fraction. It drives NaNs whose payload bits straddle the quiet bit and bit 21. A design that shifted the whole payload up would show bits in 50:22 and lose them from the low end. It crosses the subnormal/normal edge and the largest finite value, where a faulty unsigned range test would misclassify the word. It also checks negative zero, negative infinity and negative NaN, which a design that dropped the sign on special classes would flip positive.

// File: rtl/fp_widen_pkg.sv
package fp_widen_pkg;
  localparam int SRC_EXP_W  = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_EXP_W  = 11;
  localparam int DST_FRAC_W = 52;

  localparam int SRC_W      = 1 + SRC_EXP_W + SRC_FRAC_W;
  localparam int DST_W      = 1 + DST_EXP_W + DST_FRAC_W;
  localparam int SRC_MAG_W  = SRC_W - 1;
  localparam int DST_MAG_W  = DST_W - 1;
  localparam int FRAC_PAD   = DST_FRAC_W - SRC_FRAC_W;
  localparam int LZ_W       = $clog2(SRC_FRAC_W + 1);
  localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF  = DST_BIAS - SRC_BIAS;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fp_class_e;
endpackage

// File: rtl/fw_classify.sv
module fw_classify
  import fp_widen_pkg::*;
(
  input  logic [SRC_MAG_W-1:0] mag,
  output fp_class_e            cls
);
  localparam logic [SRC_MAG_W-1:0] MIN_NORM = SRC_MAG_W'(1) << SRC_FRAC_W;
  localparam logic [SRC_MAG_W-1:0] INF_PAT  = SRC_MAG_W'((1 << SRC_EXP_W) - 1) << SRC_FRAC_W;

  logic [SRC_MAG_W-1:0] off_norm;
  logic                 is_norm;
  logic                 is_top;

  always_comb begin
    off_norm = mag - MIN_NORM;
    is_norm  = off_norm < (INF_PAT - MIN_NORM);
    is_top   = mag >= INF_PAT;
    if (is_norm)                   cls = CLS_NORM;
    else if (is_top && mag == INF_PAT) cls = CLS_INF;
    else if (is_top)               cls = CLS_NAN;
    else if (mag != '0)            cls = CLS_SUB;
    else                           cls = CLS_ZERO;
  end
endmodule

// File: rtl/fw_lzc.sv
module fw_lzc #(
  parameter int W   = 23,
  parameter int C_W = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec,
  output logic [C_W-1:0] cnt
);
  always_comb begin
    cnt = C_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = C_W'(W - 1 - i);
    end
  end

  always_comb begin
    if (vec != '0) begin
      p_lzc_lead_r3: assert (vec[W - 1 - int'(cnt)])
        else $error("leading one not at counted position");
    end
  end
endmodule

// File: rtl/fw_compose.sv
module fw_compose
  import fp_widen_pkg::*;
(
  input  fp_class_e             cls,
  input  logic [SRC_EXP_W-1:0]  exp_in,
  input  logic [SRC_FRAC_W-1:0] frac_in,
  input  logic [LZ_W-1:0]       lz,
  output logic [DST_MAG_W-1:0]  mag_out
);
  logic [DST_EXP_W-1:0]  exp_norm;
  logic [DST_EXP_W-1:0]  exp_sub;
  logic [SRC_FRAC_W-1:0] frac_sub;

  always_comb begin
    exp_norm = DST_EXP_W'(exp_in) + DST_EXP_W'(BIAS_DIFF);
    exp_sub  = DST_EXP_W'(BIAS_DIFF) - DST_EXP_W'(lz);
    frac_sub = (frac_in << lz) << 1;
    unique case (cls)
      CLS_NORM: mag_out = {exp_norm, frac_in, {FRAC_PAD{1'b0}}};
      CLS_SUB:  mag_out = {exp_sub, frac_sub, {FRAC_PAD{1'b0}}};
      CLS_INF,
      CLS_NAN:  mag_out = {{DST_EXP_W{1'b1}}, frac_in[SRC_FRAC_W-1],
                           {FRAC_PAD{1'b0}}, frac_in[SRC_FRAC_W-2:0]};
      default:  mag_out = '0;
    endcase
  end
endmodule

// File: rtl/fp_widen_s2d.sv
module fp_widen_s2d
  import fp_widen_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SRC_W-1:0]  in_word,
  output logic              out_valid,
  output logic [DST_W-1:0]  out_word
);
  fp_class_e            cls;
  logic [LZ_W-1:0]      lz;
  logic [DST_MAG_W-1:0] mag;
  logic [DST_W-1:0]     res;

  fw_classify u_cls (
    .mag (in_word[SRC_MAG_W-1:0]),
    .cls (cls)
  );

  fw_lzc #(.W(SRC_FRAC_W), .C_W(LZ_W)) u_lzc (
    .vec (in_word[SRC_FRAC_W-1:0]),
    .cnt (lz)
  );

  fw_compose u_cmp (
    .cls     (cls),
    .exp_in  (in_word[SRC_W-2:SRC_FRAC_W]),
    .frac_in (in_word[SRC_FRAC_W-1:0]),
    .lz      (lz),
    .mag_out (mag)
  );

  assign res = {in_word[SRC_W-1], mag};

  generate
    if (REG_OUT) begin : g_reg
      logic             vld_d, vld_q;
      logic [DST_W-1:0] word_d, word_q;

      always_comb begin
        vld_d  = in_valid;
        word_d = in_valid ? res : word_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        word_q <= word_d;
      end

      assign out_valid = vld_q;
      assign out_word  = word_q;

      p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));
      p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[DST_W-1] == $past(in_word[SRC_W-1]));
      p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[SRC_MAG_W-1:0] == '0) |=> out_word[DST_MAG_W-1:0] == '0);
      p_top_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && &in_word[SRC_W-2:SRC_FRAC_W]) |=> &out_word[DST_W-2:DST_FRAC_W]);
      p_nan_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && &in_word[SRC_W-2:SRC_FRAC_W])
          |=> out_word[DST_FRAC_W-2:SRC_FRAC_W-1] == '0);
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_word  = res;
    end
  endgenerate

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r9: assert (!out_valid || !REG_OUT) else $error("valid during reset");
    end
  end
endmodule

// File: tb/fp_widen_s2d_tb.sv
module fp_widen_s2d_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [63:0] out_word;

  int tests_run    = 0;
  int tests_failed = 0;
  bit done         = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_widen_s2d dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  function automatic logic [63:0] ref_conv(input logic [31:0] a);
    logic        s;
    int          e;
    logic [23:0] m;
    s = a[31];
    e = int'(a[30:23]);
    m = {1'b0, a[22:0]};
    if (e == 0 && m == 0) return {s, 63'd0};
    if (e == 0) begin
      e = -126;
      while (!m[23]) begin
        m = m << 1;
        e = e - 1;
      end
    end else begin
      e = e - 127;
    end
    return {s, 11'(e + 1023), m[22:0], 29'd0};
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check1({tag, " R7 valid"}, out_valid, 1'b1);
    check64(tag, out_word, exp);
  endtask

  task automatic t_reset();
    check1("R9 valid low in reset", out_valid, 1'b0);
  endtask

  task automatic t_normal();
    apply("R1 one", 32'h3F80_0000, 64'h3FF0_0000_0000_0000);
    apply("R1 pi", 32'h4049_0FDB, ref_conv(32'h4049_0FDB));
    for (int k = 1; k < 255; k += 23) begin
      logic [31:0] w;
      w = {1'b0, 8'(k), 23'h2A_5C3B ^ 23'(k * 977)};
      apply("R1 sweep", w, ref_conv(w));
    end
  endtask

  task automatic t_zero();
    apply("R2 pos zero", 32'h0000_0000, 64'h0000_0000_0000_0000);
    apply("R2 neg zero R6", 32'h8000_0000, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_subnormal();
    apply("R3 min sub", 32'h0000_0001, 64'h36A0_0000_0000_0000);
    for (int p = 0; p < 23; p++) begin
      logic [31:0] w;
      w = 32'h1 << p;
      apply("R3 single bit", w, ref_conv(w));
      w = w | (32'h1 << (p / 2));
      apply("R3 two bits", w, ref_conv(w));
    end
    apply("R3 neg sub R6", 32'h8000_0003, ref_conv(32'h8000_0003));
  endtask

  task automatic t_boundary();
    apply("R10 max sub", 32'h007F_FFFF, 64'h380F_FFFF_C000_0000);
    apply("R10 min norm", 32'h0080_0000, 64'h3810_0000_0000_0000);
    apply("R10 max norm", 32'h7F7F_FFFF, 64'h47EF_FFFF_E000_0000);
  endtask

  task automatic t_special();
    apply("R4 pos inf", 32'h7F80_0000, 64'h7FF0_0000_0000_0000);
    apply("R4 neg inf R6", 32'hFF80_0000, 64'hFFF0_0000_0000_0000);
    apply("R5 quiet nan", 32'h7FC0_0001, 64'h7FF8_0000_0000_0001);
    apply("R5 signalling nan", 32'h7F80_0001, 64'h7FF0_0000_0000_0001);
    apply("R5 bit21 payload", 32'h7FA0_0000, 64'h7FF0_0000_0020_0000);
    apply("R5 neg full nan R6", 32'hFFFF_FFFF, 64'hFFF8_0000_003F_FFFF);
  endtask

  task automatic t_hold();
    logic [63:0] prev;
    apply("R8 load", 32'h4000_0000, 64'h4000_0000_0000_0000);
    prev = out_word;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'hC2F6_E979;
    @(negedge clk);
    check1("R8 valid drops", out_valid, 1'b0);
    check64("R8 word held", out_word, prev);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_zero();
    t_subnormal();
    t_boundary();
    t_special();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule